// File: doc/BRIEF.md
# Page-Table Entry Cache

A small direct-mapped cache that sits between a translation walker and memory and keeps recently fetched 32-bit page-table words. The walker sends tagged read requests by physical byte address (34 bits). A hit answers one cycle after acceptance. A miss becomes a read of one whole atom-sized line from memory. Lookups continue while misses are outstanding, so a hit can be answered before an earlier miss. Every response carries the tag of its request.

The cache does not snoop. Software that rewrites a table entry must then issue a flush command. The command word chooses, through its bit 0, between dropping every line and dropping the single line that holds one physical address. The top two address bits for the flush come from a separately written high register. A configuration word turns the cache on, caps the number of memory reads in flight, and supplies a value that is XORed into the set index.

Top module: `pte_cache`

## Requirements
- R1: After reset the cache is disabled with no outstanding reads, no response and no memory request. The limit and the index-map value are both zero.
- R2: When the cache is enabled and the line holding an accepted address is resident, the stored word is returned with the request's tag in the cycle after acceptance, and no memory read is issued.
- R3: When the cache is enabled and the line is not resident, the accepted request issues a memory read in the same cycle at the line address (byte address with the low 5 bits cleared for the default 32-byte line). The line returned is installed. The word chosen by address bits [4:2] is returned with the tag in the cycle after the line arrives.
- R4: Config bit 29 enables the cache. While it is 0, every accepted read issues a memory read and nothing is installed, so a repeated read misses again.
- R5: Config bits [27:24] cap the number of memory reads in flight. At the cap, a request that would miss is held (req_ready low) and no memory read issues. A value of 0 removes the cap, leaving only the pending-queue depth (8 by default).
- R6: A flush command with bit 0 = 0 invalidates every line.
- R7: A flush command with bit 0 = 1 forms the address {high[1:0], cmd[31:1], 0} and rounds it down to the line. Only that line is invalidated, and other lines keep hitting.
- R8: The high register keeps its bits [1:0] until rewritten and applies to every later flush-by-address. A flush whose high bits differ from a resident line's bits [33:32] leaves that line resident.
- R9: Config bits [5:0] are XORed into the set index. After the value changes, a line installed under the old value is no longer found and misses.
- R10: When a flush covering a line arrives while that line's memory read is in flight, the data is still returned to the walker but the line is not installed.
- R11: In a cycle where memory returns a line, no walker request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (enable bit 29, limit [27:24], index map [5:0]) |
| fl_hi_wr | input | 1 | Flush-high register write strobe |
| fl_hi_data | input | 2 | Physical address bits [33:32] for flush-by-address |
| fl_cmd_wr | input | 1 | Flush command strobe |
| fl_cmd_data | input | 32 | Flush command: bit 0 type, bits [31:1] low address |
| req_valid | input | 1 | Walker read request valid |
| req_ready | output | 1 | Walker request accepted this cycle |
| req_addr | input | 34 | Physical byte address of the table word |
| req_id | input | ID_W | Request tag |
| resp_valid | output | 1 | Response valid |
| resp_id | output | ID_W | Tag of the answered request |
| resp_data | output | 32 | Table word |
| mem_req_valid | output | 1 | Memory line read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 34 | Line-aligned byte address |
| mem_rsp_valid | input | 1 | Line data returned, in request order |
| mem_rsp_data | input | ATOM_BYTES*8 | Line data, word 0 in the low bits |

## Verification
A stale valid bit or tag shows up at the ports as a hit answered one cycle after acceptance with no memory read, where a miss with a memory read was due. The bench therefore counts memory reads around every lookup and checks the response cycle. A wrong in-flight count or a lost install-suppress mark appears within a few cycles: either a request is held or passes against the programmed cap, or a line flushed during its fetch is hit on the very next read. Wrong word selection or a wrong XOR on the index shows up in the first response after the change, as wrong data or a hit or miss that should have gone the other way.

// File: rtl/pec_pkg.sv
package pec_pkg;
    localparam int PA_W   = 34;
    localparam int WORD_W = 32;

    localparam int CFG_EN_BIT  = 29;
    localparam int CFG_LIM_LSB = 24;
    localparam int CFG_MAP_LSB = 0;

    typedef struct packed {
        logic       enable;
        logic [3:0] limit;
        logic [5:0] imap;
    } pec_cfg_t;

    typedef enum logic {
        FL_ALL  = 1'b0,
        FL_ADDR = 1'b1
    } pec_flush_kind_e;
endpackage

// File: rtl/pec_cfg_regs.sv
module pec_cfg_regs
    import pec_pkg::*;
#(
    parameter int OFF_W = 5,
    parameter int LA_W  = PA_W - OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [31:0]     cfg_wdata,
    input  logic            hi_wr,
    input  logic [1:0]      hi_wdata,
    input  logic            flush_wr,
    input  logic [31:0]     flush_wdata,
    output pec_cfg_t        cfg,
    output logic            flush_all,
    output logic            flush_line,
    output logic [LA_W-1:0] flush_line_addr
);
    typedef struct packed {
        pec_cfg_t   cfg;
        logic [1:0] hi;
    } regs_t;

    regs_t           regs_d, regs_q;
    pec_flush_kind_e kind;
    logic [PA_W-1:0] full_addr;
    logic            unused_bits;

    always_comb begin
        regs_d = regs_q;
        if (cfg_wr) begin
            regs_d.cfg.enable = cfg_wdata[CFG_EN_BIT];
            regs_d.cfg.limit  = cfg_wdata[CFG_LIM_LSB +: 4];
            regs_d.cfg.imap   = cfg_wdata[CFG_MAP_LSB +: 6];
        end
        if (hi_wr) regs_d.hi = hi_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // The flush uses the high bits already latched, never the ones written in the same cycle
    always_comb begin
        kind            = pec_flush_kind_e'(flush_wdata[0]);
        flush_all       = flush_wr && (kind == FL_ALL);
        flush_line      = flush_wr && (kind == FL_ADDR);
        full_addr       = {regs_q.hi, flush_wdata[31:1], 1'b0};
        flush_line_addr = full_addr[PA_W-1:OFF_W];
    end

    assign cfg         = regs_q.cfg;
    assign unused_bits = ^{cfg_wdata[31:30], cfg_wdata[28], cfg_wdata[23:6], full_addr[OFF_W-1:0]};

    a_r8_hi_held: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr |=> regs_q.hi == $past(regs_q.hi));
endmodule

// File: rtl/pec_pending.sv
module pec_pending #(
    parameter int ID_W   = 4,
    parameter int LA_W   = 29,
    parameter int WSEL_W = 3,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [WSEL_W-1:0] push_wsel,
    input  logic [LA_W-1:0]   push_line,
    input  logic              push_noalloc,
    input  logic              pop,
    input  logic              kill_all,
    input  logic              kill_line_en,
    input  logic [LA_W-1:0]   kill_line,
    output logic [ID_W-1:0]   head_id,
    output logic [WSEL_W-1:0] head_wsel,
    output logic [LA_W-1:0]   head_line,
    output logic              head_noalloc,
    output logic [CNT_W-1:0]  count,
    output logic              full
);
    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [WSEL_W-1:0] wsel;
        logic [LA_W-1:0]   line;
        logic              noalloc;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A flush marks every matching fill in flight so that it will not be installed
        for (int i = 0; i < DEPTH; i++) begin
            if (kill_all || (kill_line_en && st_q.ent[i].line == kill_line))
                st_d.ent[i].noalloc = 1'b1;
        end
        if (push) begin
            st_d.ent[st_q.wr] = '{id: push_id, wsel: push_wsel, line: push_line, noalloc: push_noalloc};
            st_d.wr = st_q.wr + 1'b1;
        end
        if (pop) st_d.rd = st_q.rd + 1'b1;
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_id      = st_q.ent[st_q.rd].id;
    assign head_wsel    = st_q.ent[st_q.rd].wsel;
    assign head_line    = st_q.ent[st_q.rd].line;
    assign head_noalloc = st_q.ent[st_q.rd].noalloc;
    assign count        = st_q.cnt;
    assign full         = (st_q.cnt == CNT_W'(DEPTH));

    a_r5_depth: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.cnt != '0);
    a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> st_q.cnt != CNT_W'(DEPTH) || pop);
endmodule

// File: rtl/pec_tag_store.sv
module pec_tag_store #(
    parameter int SETS   = 16,
    parameter int LA_W   = 29,
    parameter int LINE_W = 256,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_set,
    input  logic [LA_W-1:0]   lk_line,
    output logic              lk_hit,
    output logic [LINE_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_set,
    input  logic [LA_W-1:0]   fill_line,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              inv_all,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_set,
    input  logic [LA_W-1:0]   inv_line
);
    // The whole line address is kept as the tag, so a change of index map cannot alias
    typedef struct packed {
        logic [SETS-1:0]             valid;
        logic [SETS-1:0][LA_W-1:0]   tag;
        logic [SETS-1:0][LINE_W-1:0] data;
    } arr_t;

    arr_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (inv_all) arr_d.valid = '0;
        if (inv_en && arr_q.tag[inv_set] == inv_line) arr_d.valid[inv_set] = 1'b0;
        if (fill_en) begin
            arr_d.valid[fill_set] = 1'b1;
            arr_d.tag[fill_set]   = fill_line;
            arr_d.data[fill_set]  = fill_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arr_q <= '0;
        else        arr_q <= arr_d;
    end

    assign lk_hit  = arr_q.valid[lk_set] && (arr_q.tag[lk_set] == lk_line);
    assign lk_data = arr_q.data[lk_set];

    a_r6_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> arr_q.valid == '0);
    a_r3_fill_resident: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> arr_q.valid[$past(fill_set)] && arr_q.tag[$past(fill_set)] == $past(fill_line));
    a_r7_line_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en && arr_q.tag[inv_set] == inv_line && !(fill_en && fill_set == inv_set)
        |=> !arr_q.valid[$past(inv_set)]);
endmodule

// File: rtl/pte_cache.sv
module pte_cache
    import pec_pkg::*;
#(
    parameter int ID_W       = 4,
    parameter int SETS       = 16,
    parameter int ATOM_BYTES = 32,
    parameter int PEND_DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [31:0]             cfg_wdata,
    input  logic                    fl_hi_wr,
    input  logic [1:0]              fl_hi_data,
    input  logic                    fl_cmd_wr,
    input  logic [31:0]             fl_cmd_data,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [33:0]             req_addr,
    input  logic [ID_W-1:0]         req_id,
    output logic                    resp_valid,
    output logic [ID_W-1:0]         resp_id,
    output logic [31:0]             resp_data,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [33:0]             mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [ATOM_BYTES*8-1:0] mem_rsp_data
);
    localparam int OFF_W  = $clog2(ATOM_BYTES);
    localparam int LA_W   = PA_W - OFF_W;
    localparam int LINE_W = ATOM_BYTES * 8;
    localparam int WPL    = ATOM_BYTES / 4;
    localparam int WSEL_W = $clog2(WPL);
    localparam int IDX_W  = $clog2(SETS);
    localparam int CNT_W  = $clog2(PEND_DEPTH + 1);

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [WORD_W-1:0] data;
    } rsp_t;

    pec_cfg_t          cfg;
    logic              fl_all, fl_line;
    logic [LA_W-1:0]   fl_line_addr;
    logic [LA_W-1:0]   req_line;
    logic [WSEL_W-1:0] req_wsel;
    logic [IDX_W-1:0]  req_set, fill_set, inv_set;
    logic              ts_hit, hit, under_lim, push;
    logic [LINE_W-1:0] ts_data;
    logic [ID_W-1:0]   hd_id;
    logic [WSEL_W-1:0] hd_wsel;
    logic [LA_W-1:0]   hd_line;
    logic              hd_noalloc, kill_head, fill_en;
    logic [CNT_W-1:0]  pend_cnt;
    logic              pend_full;
    rsp_t              rsp_d, rsp_q;
    logic [1:0]        unused_lsb;

    function automatic logic [IDX_W-1:0] map_set(input logic [LA_W-1:0] line, input logic [5:0] imap);
        logic [IDX_W+5:0] ext;
        ext = {{IDX_W{1'b0}}, imap};
        return line[IDX_W-1:0] ^ ext[IDX_W-1:0];
    endfunction

    pec_cfg_regs #(.OFF_W(OFF_W), .LA_W(LA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .hi_wr(fl_hi_wr), .hi_wdata(fl_hi_data),
        .flush_wr(fl_cmd_wr), .flush_wdata(fl_cmd_data),
        .cfg(cfg), .flush_all(fl_all), .flush_line(fl_line), .flush_line_addr(fl_line_addr)
    );

    assign req_line   = req_addr[PA_W-1:OFF_W];
    assign req_wsel   = req_addr[OFF_W-1:2];
    assign unused_lsb = req_addr[1:0];
    assign req_set    = map_set(req_line, cfg.imap);
    assign inv_set    = map_set(fl_line_addr, cfg.imap);
    assign fill_set   = map_set(hd_line, cfg.imap);

    // Lookup and acceptance: a returning line takes the response slot for this cycle
    always_comb begin
        hit       = cfg.enable && ts_hit;
        under_lim = ((cfg.limit == 4'd0) || (int'(pend_cnt) < int'(cfg.limit))) && !pend_full;
        req_ready = !mem_rsp_valid && (hit || (under_lim && mem_req_ready));
        mem_req_valid = req_valid && !mem_rsp_valid && !hit && under_lim;
        mem_req_addr  = {req_line, {OFF_W{1'b0}}};
        push      = mem_req_valid && mem_req_ready;
        kill_head = fl_all || (fl_line && fl_line_addr == hd_line);
        fill_en   = mem_rsp_valid && cfg.enable && !hd_noalloc && !kill_head;
    end

    always_comb begin
        rsp_d = '0;
        if (mem_rsp_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.id    = hd_id;
            rsp_d.data  = mem_rsp_data[hd_wsel*WORD_W +: WORD_W];
        end else if (req_valid && req_ready && hit) begin
            rsp_d.valid = 1'b1;
            rsp_d.id    = req_id;
            rsp_d.data  = ts_data[req_wsel*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign resp_valid = rsp_q.valid;
    assign resp_id    = rsp_q.id;
    assign resp_data  = rsp_q.data;

    pec_pending #(.ID_W(ID_W), .LA_W(LA_W), .WSEL_W(WSEL_W), .DEPTH(PEND_DEPTH)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_id(req_id), .push_wsel(req_wsel), .push_line(req_line),
        .push_noalloc(!cfg.enable),
        .pop(mem_rsp_valid),
        .kill_all(fl_all), .kill_line_en(fl_line), .kill_line(fl_line_addr),
        .head_id(hd_id), .head_wsel(hd_wsel), .head_line(hd_line), .head_noalloc(hd_noalloc),
        .count(pend_cnt), .full(pend_full)
    );

    pec_tag_store #(.SETS(SETS), .LA_W(LA_W), .LINE_W(LINE_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(req_set), .lk_line(req_line), .lk_hit(ts_hit), .lk_data(ts_data),
        .fill_en(fill_en), .fill_set(fill_set), .fill_line(hd_line), .fill_data(mem_rsp_data),
        .inv_all(fl_all), .inv_en(fl_line), .inv_set(inv_set), .inv_line(fl_line_addr)
    );

    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !mem_req_valid |=> resp_valid && resp_id == $past(req_id));
    a_r3_line_answered: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |=> resp_valid && resp_id == $past(hd_id));
    a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.enable && req_valid && req_ready |-> mem_req_valid);
    a_r5_limit: assert property (@(posedge clk) disable iff (!rst_n)
        push && cfg.limit != 4'd0 |=> int'(pend_cnt) <= int'($past(cfg.limit)));
    a_r11_no_accept_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !(req_valid && req_ready));
endmodule

// File: tb/pte_cache_bench.sv
module pte_cache_bench;
    localparam int CLK_P = 10;
    localparam int ID_W  = 4;
    localparam int LW    = 256;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 0, fl_hi_wr = 0, fl_cmd_wr = 0, req_valid = 0;
    logic [31:0] cfg_wdata = 0, fl_cmd_data = 0;
    logic [1:0]  fl_hi_data = 0;
    logic [33:0] req_addr = 0;
    logic [ID_W-1:0] req_id = 0;
    logic req_ready, resp_valid, mem_req_valid;
    logic [ID_W-1:0] resp_id;
    logic [31:0] resp_data;
    logic [33:0] mem_req_addr;
    logic mem_req_ready = 1'b1, mem_rsp_valid = 1'b0;
    logic [LW-1:0] mem_rsp_data = '0;

    pte_cache u_pte_cache (.*);

    always #(CLK_P/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, nreq = 0;
    logic [28:0] q_line [16];
    int q_wr = 0, q_rd = 0;
    logic rsp_en = 1'b1;
    logic [33:0] last_mem_addr;
    logic [31:0] got_data [16];
    logic got_v [16];
    int got_cyc [16];

    function automatic logic [31:0] mw(input logic [33:0] a);
        return {a[33:32], a[31:2]} ^ 32'h5A00_00C3;
    endfunction

    function automatic logic [LW-1:0] line_of(input logic [28:0] l);
        logic [LW-1:0] d;
        for (int i = 0; i < 8; i++) d[i*32 +: 32] = mw({l, 5'b0} + 34'(i*4));
        return d;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Logger: responses, cycle stamps and memory reads
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (resp_valid) begin
            got_data[resp_id] = resp_data;
            got_v[resp_id]    = 1'b1;
            got_cyc[resp_id]  = cyc;
        end
        if (mem_req_valid && mem_req_ready) begin
            q_line[q_wr % 16] = mem_req_addr[33:5];
            q_wr = q_wr + 1;
            nreq = nreq + 1;
            last_mem_addr = mem_req_addr;
        end
    end

    // Memory responder, one line per cycle in order
    initial forever begin
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        if (rsp_en && q_rd != q_wr) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = line_of(q_line[q_rd % 16]);
            q_rd = q_rd + 1;
            #1;
            chk(!req_ready, "R11", 64'(req_ready), 0);
        end
    end

    task automatic wr_cfg(input logic en, input logic [3:0] lim, input logic [5:0] imap);
        @(negedge clk);
        cfg_wr = 1; cfg_wdata = (32'(en) << 29) | (32'(lim) << 24) | 32'(imap);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic wr_hi(input logic [1:0] v);
        @(negedge clk); fl_hi_wr = 1; fl_hi_data = v;
        @(negedge clk); fl_hi_wr = 0;
    endtask

    task automatic flush(input logic [31:0] cmd);
        @(negedge clk); fl_cmd_wr = 1; fl_cmd_data = cmd;
        @(negedge clk); fl_cmd_wr = 0;
    endtask

    task automatic issue(input logic [33:0] a, input logic [ID_W-1:0] id, output logic missed, output int acc);
        int t = 0;
        got_v[id] = 0;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_id = id;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
            t++;
            if (t > 200) break;
        end
        missed = mem_req_valid;
        @(negedge clk);
        acc = cyc;
        req_valid = 0;
    endtask

    task automatic wait_rsp(input logic [ID_W-1:0] id);
        for (int t = 0; t < 200 && !got_v[id]; t++) @(negedge clk);
    endtask

    task automatic rd(input logic [33:0] a, input logic [ID_W-1:0] id, input logic exp_miss, input string req);
        logic m; int acc;
        issue(a, id, m, acc);
        wait_rsp(id);
        chk(m == exp_miss, req, 64'(m), 64'(exp_miss));
        chk(got_v[id] && got_data[id] == mw(a), req, 64'(got_data[id]), 64'(mw(a)));
        if (!exp_miss) chk(got_cyc[id] == acc + 1, {req, " latency"}, 64'(got_cyc[id]), 64'(acc + 1));
        else chk(last_mem_addr == {a[33:5], 5'b0}, {req, " line addr"}, 64'(last_mem_addr), 64'({a[33:5], 5'b0}));
    endtask

    localparam logic [33:0] A = 34'h0_1000_0044, B = 34'h0_1000_0080;
    localparam logic [33:0] C = 34'h2_0000_0100, D = 34'h2_0000_01A0;
    localparam logic [33:0] E = 34'h0_0000_0300, F = 34'h0_0040_0060;

    task automatic t_reset;
        chk(!resp_valid && !mem_req_valid, "R1", 64'({resp_valid, mem_req_valid}), 0);
        rd(A, 1, 1'b1, "R1");
        rd(A, 2, 1'b1, "R4");
    endtask

    task automatic t_miss_hit;
        wr_cfg(1, 0, 0);
        rd(A, 1, 1'b1, "R3");
        rd(A + 34'h8, 2, 1'b0, "R2");
        rd(A + 34'h1C - 34'h4, 3, 1'b0, "R2");
    endtask

    task automatic t_flush_all;
        rd(B, 4, 1'b1, "R3");
        flush(32'h0);
        rd(A, 5, 1'b1, "R6");
        rd(B, 6, 1'b1, "R6");
    endtask

    task automatic t_flush_addr;
        flush(A[31:0] + 32'h15);
        rd(A, 7, 1'b1, "R7");
        rd(B, 8, 1'b0, "R7");
    endtask

    task automatic t_flush_hi;
        rd(C, 9, 1'b1, "R8");
        flush(C[31:0] | 32'h1);
        rd(C, 10, 1'b0, "R8");
        wr_hi(2'd2);
        rd(D, 11, 1'b1, "R8");
        flush(C[31:0] | 32'h1);
        flush(D[31:0] | 32'h1);
        rd(C, 12, 1'b1, "R8");
        rd(D, 13, 1'b1, "R8");
    endtask

    task automatic t_imap;
        rd(E, 14, 1'b1, "R9");
        rd(E, 15, 1'b0, "R9");
        wr_cfg(1, 0, 6'd1);
        rd(E, 0, 1'b1, "R9");
        wr_cfg(1, 0, 0);
    endtask

    task automatic t_limit;
        logic m; int acc;
        wr_cfg(1, 4'd2, 0);
        rsp_en = 0;
        issue(34'h0_0300_0000, 1, m, acc);
        issue(34'h0_0300_0020, 2, m, acc);
        got_v[3] = 0;
        @(negedge clk);
        req_valid = 1; req_addr = 34'h0_0300_0040; req_id = 3;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(!req_ready && !mem_req_valid, "R5 held at cap", 64'({req_ready, mem_req_valid}), 0);
            @(negedge clk);
        end
        req_valid = 0;
        rsp_en = 1;
        issue(34'h0_0300_0040, 3, m, acc);
        chk(m, "R5 released", 64'(m), 1);
        for (int k = 1; k <= 3; k++) begin
            wait_rsp(ID_W'(k));
            chk(got_data[k] == mw(34'h0_0300_0000 + 34'((k-1)*32)), "R5 data",
                64'(got_data[k]), 64'(mw(34'h0_0300_0000 + 34'((k-1)*32))));
        end
        wr_cfg(1, 0, 0);
        rsp_en = 0;
        for (int k = 0; k < 5; k++) begin
            issue(34'h0_0400_0000 + 34'(k*32), ID_W'(k + 4), m, acc);
            chk(m && acc > 0, "R5 unlimited", 64'(m), 1);
        end
        rsp_en = 1;
        for (int k = 0; k < 5; k++) wait_rsp(ID_W'(k + 4));
        chk(got_v[8] && got_data[8] == mw(34'h0_0400_0080), "R5 unlimited data", 64'(got_data[8]), 64'(mw(34'h0_0400_0080)));
    endtask

    task automatic t_flight_flush;
        logic m; int acc;
        rsp_en = 0;
        issue(F, 9, m, acc);
        flush(32'h0);
        rsp_en = 1;
        wait_rsp(9);
        chk(got_v[9] && got_data[9] == mw(F), "R10 data", 64'(got_data[9]), 64'(mw(F)));
        rd(F, 10, 1'b1, "R10");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) got_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_miss_hit();
        t_flush_all();
        t_flush_addr();
        t_flush_hi();
        t_imap();
        t_limit();
        t_flight_flush();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule